// File: doc/BRIEF.md
# Speaker Toggle PCM Sample Generator

This block turns a 1-bit speaker that a processor flips by strobing a control address into signed 16-bit mono audio for a 44100 Hz playback path. It watches a free-running processor cycle count together with a single-cycle toggle strobe. For each toggle it measures the cycles since the previous one and writes a burst of samples into a small output FIFO. A burst is a two-sample edge spike, followed by a flat run whose length is proportional to the measured interval. Its sign follows a polarity bit that alternates from one toggle to the next.

One output sample stands for a fixed number of processor cycles (70 by default). When the speaker goes quiet for longer than an idle limit (1000 cycles by default) after samples have been produced, the block raises a one-cycle flush indication so that the consumer can play out the block it has collected. It then returns to its post-reset state. The consumer drains samples through a valid/ready port. If the FIFO is full, new samples are discarded and a sticky flag records the loss.

Top module: `spkr_pcm_gen`

## Requirements
- R1: While reset (rstN low) is asserted, and directly after it is released, sampleValid, flushPulse and overflowFlag are all 0.
- R2: The first accepted toggle after reset or after a flush only stores its cycle stamp and inverts the polarity, which starts low. It writes no samples.
- R3: Every later accepted toggle first writes two samples: 0, then +26214 when the polarity is high or -26214 when it is low.
- R4: After the edge pair the block writes N level samples of +16384 (polarity high) or -16384 (polarity low). N is the cycles since the previous accepted toggle divided by 70, rounded down. The polarity then inverts, so consecutive bursts alternate in sign.
- R5: N is clamped at MAX_RUN (4095 by default), however long the interval is.
- R6: The interval is taken modulo 2^32, so a wrap of cycleCount between two toggles still gives the true interval.
- R7: A toggle strobe that arrives while a burst is still being written is ignored and leaves the stored stamp unchanged. A burst with run length N occupies the generator for N+3 clocks from the edge that accepts its toggle.
- R8: When samples have been written since the last flush or reset, a stamp is held, no toggle is present and cycleCount minus the stamp exceeds 1000, flushPulse is high for exactly one clock on the next cycle. The polarity then returns low and the next toggle counts as a first toggle.
- R9: Samples leave in the order they were written. While sampleValid is high and sampleReady is low, sampleData holds.
- R10: A sample written while the FIFO (16 entries by default) is full is dropped, and overflowFlag goes high and stays high until reset.
- R11: The only sample values ever presented are 0, +/-16384 and +/-26214.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the cycle counter source |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleCount | input | CNT_W (32) | Free-running processor cycle count |
| toggleStrobe | input | 1 | One-cycle speaker toggle event |
| sampleData | output | 16 | Signed PCM sample at the FIFO head |
| sampleValid | output | 1 | FIFO head holds a sample |
| sampleReady | input | 1 | Consumer takes the head sample when valid |
| flushPulse | output | 1 | One-cycle idle flush of the collected block |
| overflowFlag | output | 1 | Sticky: a sample was lost to a full FIFO |

## Verification
The bench aims at the run-length arithmetic at its edges: an interval just under one sample period, an interval large enough to hit the clamp, and an interval that straddles a counter wrap. A design that divides wrongly or misses the clamp would give bursts of the wrong length there, and the wrap case would produce a huge burst. It strobes a second toggle into a burst in progress and then checks the next interval. A design that accepted the stray strobe would emit an extra burst or measure from the wrong stamp. It lets the speaker idle into a flush and checks that the next toggle is silent and the one after it is positive. It also starves the consumer until the FIFO overflows, which catches a design that overwrites queued samples or lets the loss flag clear.

// File: rtl/spkr_pcm_pkg.sv
package spkr_pcm_pkg;

  localparam int SAMPLE_W   = 16;
  localparam int FULL_SCALE = 32767;
  // scaled full-scale levels, rounded to nearest
  localparam logic signed [SAMPLE_W-1:0] PEAK_MAG  = SAMPLE_W'((FULL_SCALE * 8 + 5) / 10);
  localparam logic signed [SAMPLE_W-1:0] LEVEL_MAG = SAMPLE_W'((FULL_SCALE * 5 + 5) / 10);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EDGE0 = 2'd1,
    ST_EDGE1 = 2'd2,
    ST_RUN   = 2'd3
  } genState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armFirst;
    logic startBurst;
    logic pushZero;
    logic pushPeak;
    logic pushLevel;
    logic flipPol;
    logic flushBlock;
  } genCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic stampValid;
    logic runDone;
    logic idleExpired;
  } genStat_t;

endpackage

// File: rtl/spkr_sample_fifo.sv
module spkr_sample_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  output logic              full,
  output logic [DATA_W-1:0] headData,
  output logic              headValid,
  input  logic              headReady
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [AW:0]       count;
  logic              wrEn, rdEn;

  assign full      = (count == (AW+1)'(DEPTH));
  assign headValid = (count != '0);
  assign headData  = mem[rdPtr];
  assign wrEn      = pushValid && !full;
  assign rdEn      = headValid && headReady;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= bump(wrPtr);
      if (rdEn) rdPtr <= bump(rdPtr);
      case ({wrEn, rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= pushData;
  end

endmodule

// File: rtl/spkr_gen_ctrl.sv
module spkr_gen_ctrl
  import spkr_pcm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     toggleStrobe,
  input  genStat_t stat,
  output genCtl_t  ctl
);
  genState_t state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (toggleStrobe) begin
          if (!stat.stampValid) begin
            ctl.armFirst = 1'b1;
          end else begin
            ctl.startBurst = 1'b1;
            nextState      = ST_EDGE0;
          end
        end else if (stat.idleExpired) begin
          ctl.flushBlock = 1'b1;
        end
      end
      ST_EDGE0: begin
        ctl.pushZero = 1'b1;
        nextState    = ST_EDGE1;
      end
      ST_EDGE1: begin
        ctl.pushPeak = 1'b1;
        nextState    = ST_RUN;
      end
      ST_RUN: begin
        if (stat.runDone) begin
          ctl.flipPol = 1'b1;
          nextState   = ST_IDLE;
        end else begin
          ctl.pushLevel = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/spkr_gen_datapath.sv
module spkr_gen_datapath
  import spkr_pcm_pkg::*;
#(
  parameter int CNT_W          = 32,
  parameter int CYC_PER_SAMPLE = 70,
  parameter int IDLE_LIMIT     = 1000,
  parameter int MAX_RUN        = 4095
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    cycleCount,
  input  genCtl_t             ctl,
  input  logic                fifoFull,
  output genStat_t            stat,
  output logic                pushValid,
  output logic [SAMPLE_W-1:0] pushData,
  output logic                flushPulse,
  output logic                overflowFlag
);
  localparam int RUN_W = $clog2(MAX_RUN + 1);

  logic [CNT_W-1:0] lastStamp;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] remaining;
  logic [RUN_W-1:0] runCnt;
  logic             stampValid;
  logic             polarity;
  logic             blockHasData;

  // modulo-2^CNT_W interval since the stored stamp
  assign elapsed = cycleCount - lastStamp;

  assign stat.stampValid  = stampValid;
  assign stat.runDone     = (remaining < CNT_W'(CYC_PER_SAMPLE)) ||
                            (runCnt == RUN_W'(MAX_RUN));
  assign stat.idleExpired = stampValid && blockHasData &&
                            (elapsed > CNT_W'(IDLE_LIMIT));

  assign pushValid = ctl.pushZero | ctl.pushPeak | ctl.pushLevel;

  always_comb begin
    pushData = '0;
    if (ctl.pushPeak)  pushData = polarity ? PEAK_MAG  : -PEAK_MAG;
    if (ctl.pushLevel) pushData = polarity ? LEVEL_MAG : -LEVEL_MAG;
  end

  // interval bookkeeping; run length found by repeated subtraction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastStamp <= '0;
      remaining <= '0;
      runCnt    <= '0;
    end else if (ctl.armFirst) begin
      lastStamp <= cycleCount;
    end else if (ctl.startBurst) begin
      lastStamp <= cycleCount;
      remaining <= elapsed;
      runCnt    <= '0;
    end else if (ctl.pushLevel) begin
      remaining <= remaining - CNT_W'(CYC_PER_SAMPLE);
      runCnt    <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stampValid   <= 1'b0;
      polarity     <= 1'b0;
      blockHasData <= 1'b0;
    end else if (ctl.flushBlock) begin
      stampValid   <= 1'b0;
      polarity     <= 1'b0;
      blockHasData <= 1'b0;
    end else begin
      if (ctl.armFirst) stampValid <= 1'b1;
      if (ctl.armFirst || ctl.flipPol) polarity <= ~polarity;
      if (pushValid) blockHasData <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushPulse   <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      flushPulse <= ctl.flushBlock;
      if (pushValid && fifoFull) overflowFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/spkr_pcm_gen.sv
module spkr_pcm_gen
  import spkr_pcm_pkg::*;
#(
  parameter int CNT_W          = 32,
  parameter int CYC_PER_SAMPLE = 70,
  parameter int IDLE_LIMIT     = 1000,
  parameter int MAX_RUN        = 4095,
  parameter int FIFO_DEPTH     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cycleCount,
  input  logic             toggleStrobe,
  output logic [15:0]      sampleData,
  output logic             sampleValid,
  input  logic             sampleReady,
  output logic             flushPulse,
  output logic             overflowFlag
);
  genCtl_t             ctl;
  genStat_t            stat;
  logic                pushValid;
  logic [SAMPLE_W-1:0] pushData;
  logic                fifoFull;

  spkr_gen_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .toggleStrobe (toggleStrobe),
    .stat         (stat),
    .ctl          (ctl)
  );

  spkr_gen_datapath #(
    .CNT_W          (CNT_W),
    .CYC_PER_SAMPLE (CYC_PER_SAMPLE),
    .IDLE_LIMIT     (IDLE_LIMIT),
    .MAX_RUN        (MAX_RUN)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .cycleCount   (cycleCount),
    .ctl          (ctl),
    .fifoFull     (fifoFull),
    .stat         (stat),
    .pushValid    (pushValid),
    .pushData     (pushData),
    .flushPulse   (flushPulse),
    .overflowFlag (overflowFlag)
  );

  spkr_sample_fifo #(
    .DATA_W (SAMPLE_W),
    .DEPTH  (FIFO_DEPTH)
  ) i_fifo (
    .clk       (clk),
    .rstN      (rstN),
    .pushValid (pushValid),
    .pushData  (pushData),
    .full      (fifoFull),
    .headData  (sampleData),
    .headValid (sampleValid),
    .headReady (sampleReady)
  );

endmodule

// File: rtl/spkr_pcm_gen_chk.sv
module spkr_pcm_gen_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cycleCount,
  input logic             toggleStrobe,
  input logic [15:0]      sampleData,
  input logic             sampleValid,
  input logic             sampleReady,
  input logic             flushPulse,
  input logic             overflowFlag
);
  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!sampleValid && !flushPulse && !overflowFlag);
    end
  end

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !sampleReady) |=> (sampleValid && $stable(sampleData)));

  // R11
  sample_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (sampleData == 16'd0 ||
                     sampleData == 16'd16384 || sampleData == 16'hC000 ||
                     sampleData == 16'd26214 || sampleData == 16'h999A));

  // R8
  flush_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |=> !flushPulse);

  // R8
  flush_no_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |-> $past(!toggleStrobe));

endmodule

bind spkr_pcm_gen spkr_pcm_gen_chk #(.CNT_W(CNT_W)) i_spkrChk (
  .clk          (clk),
  .rstN         (rstN),
  .cycleCount   (cycleCount),
  .toggleStrobe (toggleStrobe),
  .sampleData   (sampleData),
  .sampleValid  (sampleValid),
  .sampleReady  (sampleReady),
  .flushPulse   (flushPulse),
  .overflowFlag (overflowFlag)
);

// File: tb/test_spkr_pcm_gen.sv
module test_spkr_pcm_gen;
  localparam int DEPTH = 16;
  localparam int MAXR  = 4095;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cycleCount = 32'd100;
  logic        toggleStrobe = 1'b0;
  logic        sampleReady = 1'b1;
  logic [15:0] sampleData;
  logic        sampleValid;
  logic        flushPulse;
  logic        overflowFlag;

  int total = 0;
  int bad = 0;
  int pops = 0;
  int flushSeen = 0;
  int wd = 0;
  string phase = "R1";
  logic [31:0] lastTog = 32'd0;

  always #5 clk = ~clk;

  spkr_pcm_gen i_spkr_pcm_gen (
    .clk(clk), .rstN(rstN), .cycleCount(cycleCount), .toggleStrobe(toggleStrobe),
    .sampleData(sampleData), .sampleValid(sampleValid), .sampleReady(sampleReady),
    .flushPulse(flushPulse), .overflowFlag(overflowFlag)
  );

  // ---------------- reference model ----------------
  int   mFifo[$];
  int   emitQ[$];
  int   busyLeft = 0;
  bit   mStamp = 0;
  logic [31:0] mLast = 0;
  bit   mPol = 0;
  bit   mHasData = 0;
  bit   mFlush = 0;
  bit   mOvf = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mFifo.delete(); emitQ.delete();
      busyLeft = 0; mStamp = 0; mPol = 0; mHasData = 0; mFlush = 0; mOvf = 0;
    end else begin
      bit doPop, doPush;
      int pv;
      logic [31:0] d;
      doPop = (mFifo.size() > 0) && sampleReady;
      doPush = 0; pv = 0;
      mFlush = 0;
      d = cycleCount - mLast;
      if (busyLeft > 0) begin
        busyLeft--;
        if (emitQ.size() > 0) begin
          pv = emitQ.pop_front();
          mHasData = 1;
          if (mFifo.size() == DEPTH) mOvf = 1; else doPush = 1;
        end
      end else if (toggleStrobe) begin
        if (!mStamp) begin
          mStamp = 1; mLast = cycleCount; mPol = !mPol;
        end else begin
          int n;
          n = int'(d / 70);
          if (d / 70 > MAXR) n = MAXR;
          emitQ.push_back(0);
          emitQ.push_back(mPol ? 26214 : -26214);
          for (int i = 0; i < n; i++) emitQ.push_back(mPol ? 16384 : -16384);
          busyLeft = n + 3;
          mLast = cycleCount;
          mPol = !mPol;
        end
      end else if (mStamp && mHasData && d > 32'd1000) begin
        mFlush = 1; mStamp = 0; mPol = 0; mHasData = 0;
      end
      if (doPop) void'(mFifo.pop_front());
      if (doPush) mFifo.push_back(pv);
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check(sampleValid == (mFifo.size() > 0), {phase, " valid"}, sampleValid, mFifo.size() > 0);
      if (sampleValid && mFifo.size() > 0)
        check($signed(sampleData) == mFifo[0], {phase, " data R9"}, $signed(sampleData), mFifo[0]);
      check(flushPulse == mFlush, {phase, " flush R8"}, flushPulse, mFlush);
      check(overflowFlag == mOvf, {phase, " overflow R10"}, overflowFlag, mOvf);
      if (sampleValid && sampleReady) pops++;
      if (flushPulse) flushSeen++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<150000", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      cycleCount = cycleCount + 1;
      toggleStrobe = 1'b0;
    end
  endtask

  task automatic toggleAt(input logic [31:0] v);
    @(negedge clk);
    cycleCount = v;
    toggleStrobe = 1'b1;
    lastTog = v;
  endtask

  task automatic expectPops(input string tag, input int exp);
    check(pops == exp, tag, pops, exp);
    pops = 0;
  endtask

  initial begin
    step(5);
    // R1: state during and after reset
    check(!sampleValid && !flushPulse && !overflowFlag, "R1 in reset", sampleValid, 0);
    @(negedge clk); rstN = 1'b1;
    step(1);
    check(!sampleValid && !flushPulse && !overflowFlag, "R1 after reset", overflowFlag, 0);

    phase = "R2";
    toggleAt(32'd1000);
    step(30);
    expectPops("R2 first toggle silent", 0);

    phase = "R3";
    toggleAt(lastTog + 700);   // 10 levels, positive
    step(40);
    expectPops("R3 edge+run count", 12);

    phase = "R4";
    toggleAt(lastTog + 355);   // 5 levels, negative
    step(30);
    expectPops("R4 negative burst", 7);
    toggleAt(lastTog + 69);    // below one period: edge pair only
    step(20);
    expectPops("R4 zero-length run", 2);

    phase = "R7";
    toggleAt(lastTog + 140);   // 2 levels, busy 5 clocks
    step(1);
    @(negedge clk); cycleCount = cycleCount + 1; toggleStrobe = 1'b1; // ignored
    step(20);
    expectPops("R7 stray toggle ignored", 4);
    toggleAt(lastTog + 210);   // measured from accepted stamp: 3 levels
    step(20);
    expectPops("R7 stamp kept", 5);

    phase = "R5";
    toggleAt(32'hFFFF_FF00);   // very long gap: clamped
    step(MAXR + 20);
    expectPops("R5 clamp", MAXR + 2);
    step(10);
    check(flushSeen == 1, "R8 flush after long idle", flushSeen, 1);

    phase = "R6";
    toggleAt(32'hFFFF_FF80);   // first after flush
    step(10);
    toggleAt(32'h0000_0180);   // wrapped interval 0x200 -> 7 levels
    step(30);
    expectPops("R6 wrap interval", 9);

    phase = "R8";
    step(1100);
    check(flushSeen == 2, "R8 idle flush", flushSeen, 2);
    toggleAt(cycleCount + 1);
    step(10);
    expectPops("R8 toggle after flush silent", 0);
    toggleAt(lastTog + 140);
    step(20);
    expectPops("R8 burst after flush", 4);

    phase = "R10";
    @(negedge clk); sampleReady = 1'b0; cycleCount = cycleCount + 1;
    toggleAt(lastTog + 70 * 30); // 32 samples into 16 entries
    step(40);
    check(overflowFlag == 1'b1, "R10 overflow set", overflowFlag, 1);
    check(sampleValid == 1'b1, "R9 head held", sampleValid, 1);
    @(negedge clk); sampleReady = 1'b1; cycleCount = cycleCount + 1;
    step(30);
    expectPops("R10 kept entries", DEPTH);
    check(overflowFlag == 1'b1, "R10 sticky", overflowFlag, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule